// File: doc/BRIEF.md
# Serial Audio DAC Input Register

This block is the digital front end of an 18-bit stereo audio converter. It receives a serial data line, a bit clock and a word clock, all asynchronous to the fast system clock. Each input passes through a synchronizer chain, and edges are found by comparing consecutive synchronized samples. No input is ever used as a clock. On every detected bit-clock rising edge, the synchronized data level is pushed into an 18-bit shift register. Samples are two's complement and arrive most significant bit first.

A word-clock period carries two words. The right-channel word occupies the half in which the word clock is low. The left-channel word occupies the half in which it is high. When the word clock rises, the shift register contents are parked in a right-channel staging register. When the word clock falls, the staged right word and the freshly shifted left word are written to the two output registers together. A single-cycle update strobe is raised at the same time, telling the converter core when its output should change.

A three-state controller keeps the block aligned to the framing:

- `ST_ALIGN` is entered from reset. It waits for the first word-clock falling edge, which moves it to `ST_RIGHT` without committing anything.
- `ST_RIGHT` moves to `ST_LEFT` on a word-clock rising edge and stages the right word.
- `ST_LEFT` returns to `ST_RIGHT` on a word-clock falling edge, committing both words and pulsing the strobe.

Top module: `audio_dac_deserializer`

## Requirements
- R1: While the active-low reset is asserted, both channel outputs read zero (mid-scale in two's complement) and the update strobe is low.
- R2: Serial data is sampled once per bit-clock rising edge. The word is 18-bit two's complement, most significant bit first, so the first bit sent ends up in output bit 17 and the last bit sent in output bit 0.
- R3: Only the 18 most recent bits before a word-clock transition form the word. Any bits shifted in earlier are discarded.
- R4: The word completed while the word clock is low (the first half of the period) appears on the right output. The word completed while the word clock is high appears on the left output.
- R5: Both outputs change only together with the update strobe, and only in response to a word-clock falling edge.
- R6: The update strobe is high for exactly one system-clock cycle per word-clock falling edge.
- R7: The strobe and the new outputs appear at the third system-clock rising edge that samples the word clock low. That is the depth of the two-stage synchronizer plus one register.
- R8: After reset, the first word-clock falling edge commits nothing and raises no strobe. It only aligns the framing.
- R9: A word-clock rising edge raises no strobe and leaves both outputs unchanged.
- R10: Bit-clock and data activity without a word-clock falling edge leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_in | input | 1 | Serial sample data, asynchronous |
| bclk_in | input | 1 | Bit clock, asynchronous; data is taken on its rising edge |
| wclk_in | input | 1 | Word clock, asynchronous; low half carries right, high half carries left |
| left_out | output | WORD_W (18) | Committed left-channel sample, two's complement |
| right_out | output | WORD_W (18) | Committed right-channel sample, two's complement |
| update_stb | output | 1 | One-cycle pulse when both outputs take new values |

## Verification
The bench builds the block with its defaults: WORD_W of 18 and SYNC_STAGES of 2. At these values the full-scale extremes are within reach: most positive 0x1FFFF, most negative 0x20000, and minus one 0x3FFFF. The defaults also give the exact three-cycle latency from a word-clock fall to the strobe. Frames with extra leading bits, long bursts of bit clocks with no word-clock edge, and a reset in the middle of a frame exercise the discard rule, output holding and re-alignment.

// File: rtl/dacin_pkg.sv
package dacin_pkg;
    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_RIGHT = 2'd1,
        ST_LEFT  = 2'd2
    } frame_state_e;
endpackage

// File: rtl/dacin_sync.sv
module dacin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = chain[LAST];
    end
endmodule

// File: rtl/dacin_shifter.sv
module dacin_shifter #(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_s,
    input  logic              data_s,
    output logic [WORD_W-1:0] word
);
    logic bclk_prev;
    logic shift_en;

    assign shift_en = bclk_s & ~bclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_prev <= 1'b0;
            word      <= '0;
        end else begin
            bclk_prev <= bclk_s;
            if (shift_en) word <= {word[WORD_W-2:0], data_s};
        end
    end
endmodule

// File: rtl/dacin_frame_ctrl.sv
module dacin_frame_ctrl
    import dacin_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wclk_s,
    input  logic [WORD_W-1:0] shift_word,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              update_stb
);
    frame_state_e state, state_nx;
    logic         wclk_prev;
    logic         w_rise, w_fall;
    logic [WORD_W-1:0] right_stage;

    assign w_rise = wclk_s & ~wclk_prev;
    assign w_fall = ~wclk_s & wclk_prev;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ALIGN: if (w_fall) state_nx = ST_RIGHT;
            ST_RIGHT: if (w_rise) state_nx = ST_LEFT;
            ST_LEFT:  if (w_fall) state_nx = ST_RIGHT;
            default:  state_nx = ST_ALIGN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_ALIGN;
            wclk_prev <= 1'b0;
        end else begin
            state     <= state_nx;
            wclk_prev <= wclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            right_stage <= '0;
            right_out   <= '0;
            left_out    <= '0;
            update_stb  <= 1'b0;
        end else begin
            update_stb <= 1'b0;
            unique case (state)
                ST_ALIGN: ;
                ST_RIGHT: if (w_rise) right_stage <= shift_word;
                ST_LEFT: begin
                    if (w_fall) begin
                        right_out  <= right_stage;
                        left_out   <= shift_word;
                        update_stb <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/audio_dac_deserializer.sv
module audio_dac_deserializer #(
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_in,
    input  logic              bclk_in,
    input  logic              wclk_in,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              update_stb
);
    localparam int N_IN = 3;

    logic [N_IN-1:0]   raw_in;
    logic [N_IN-1:0]   syn_in;
    logic [WORD_W-1:0] shift_word;

    assign raw_in = {wclk_in, bclk_in, sdata_in};

    dacin_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (syn_in)
    );

    dacin_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_s (syn_in[1]),
        .data_s (syn_in[0]),
        .word   (shift_word)
    );

    dacin_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wclk_s     (syn_in[2]),
        .shift_word (shift_word),
        .left_out   (left_out),
        .right_out  (right_out),
        .update_stb (update_stb)
    );
endmodule

// File: rtl/audio_dac_deserializer_chk.sv
module audio_dac_deserializer_chk #(
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wclk_in,
    input logic [WORD_W-1:0] left_out,
    input logic [WORD_W-1:0] right_out,
    input logic              update_stb
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (left_out == '0 && right_out == '0 && !update_stb));

    assert_left_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_out) |-> update_stb);

    assert_right_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_out) |-> update_stb);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |=> !update_stb);

    assert_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> !$past(wclk_in, SYNC_STAGES + 1));
endmodule

bind audio_dac_deserializer audio_dac_deserializer_chk #(
    .WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wclk_in    (wclk_in),
    .left_out   (left_out),
    .right_out  (right_out),
    .update_stb (update_stb)
);

// File: tb/audio_dac_deserializer_test.sv
module audio_dac_deserializer_test;
    localparam int PERIOD = 10;
    localparam int W      = 18;
    localparam int NVEC   = 6;
    // each entry: {right word, left word}
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {18'h1FFFF, 18'h20000},
        {18'h20000, 18'h1FFFF},
        {18'h3FFFF, 18'h00001},
        {18'h00000, 18'h3FFFF},
        {18'h2AAAA, 18'h15555},
        {18'h12345, 18'h2DCBA}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdata = 1'b0, bclk = 1'b0, wclk = 1'b1;
    logic [W-1:0] left_out, right_out;
    logic update_stb;
    int n_chk = 0, n_bad = 0, stb_seen = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) if (update_stb) stb_seen++;

    audio_dac_deserializer #(.WORD_W(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sdata_in(sdata), .bclk_in(bclk),
        .wclk_in(wclk), .left_out(left_out), .right_out(right_out),
        .update_stb(update_stb)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata = b; cyc(3);
        bclk = 1'b1; cyc(3);
        bclk = 1'b0;
    endtask

    task automatic send_word(input logic [W-1:0] w, input int lead, input logic lead_val);
        for (int i = 0; i < lead; i++) send_bit(lead_val ^ i[0]);
        for (int i = W-1; i >= 0; i--) send_bit(w[i]);
        cyc(2);
    endtask

    task automatic frame(input logic [W-1:0] r, input logic [W-1:0] l, input int lead);
        send_word(r, lead, 1'b1);
        wclk = 1'b1; cyc(6);
        send_word(l, lead, 1'b0);
        wclk = 1'b0; cyc(6);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int s0;
        cyc(4);
        chk("R1 left reset", left_out, '0);
        chk("R1 right reset", right_out, '0);
        chk("R1 strobe reset", {17'd0, update_stb}, '0);
        rst_n = 1'b1; cyc(4);

        // Alignment fall: nothing commits (R8)
        send_word(18'h0F0F0, 0, 1'b0);
        s0 = stb_seen;
        wclk = 1'b0; cyc(8);
        chk("R8 no strobe at first fall", W'(stb_seen - s0), '0);
        chk("R8 left still zero", left_out, '0);

        // Vector table walk (R2, R4, R6)
        for (int v = 0; v < NVEC; v++) begin
            s0 = stb_seen;
            frame(VEC[v][2*W-1:W], VEC[v][W-1:0], 0);
            chk("R4 R2 right word", right_out, VEC[v][2*W-1:W]);
            chk("R4 R2 left word", left_out, VEC[v][W-1:0]);
            chk("R6 one strobe per fall", W'(stb_seen - s0), 18'd1);
        end

        // Extra leading bits discarded (R3)
        frame(18'h00F0F, 18'h3C3C3, 5);
        chk("R3 right last 18 bits", right_out, 18'h00F0F);
        chk("R3 left last 18 bits", left_out, 18'h3C3C3);

        // Rising edge: no strobe, outputs held (R9)
        send_word(18'h11111, 0, 1'b0);
        s0 = stb_seen;
        wclk = 1'b1; cyc(8);
        chk("R9 no strobe at rise", W'(stb_seen - s0), '0);
        chk("R9 right held", right_out, 18'h00F0F);
        chk("R9 left held", left_out, 18'h3C3C3);

        // Bit activity without word-clock fall (R10)
        send_word(18'h2F00F, 4, 1'b1);
        chk("R10 left held", left_out, 18'h3C3C3);
        chk("R10 right held", right_out, 18'h00F0F);

        // Exact latency (R7): right staged 0x11111, left 0x2F00F
        wclk = 1'b0; cyc(2);
        chk("R7 strobe low at edge 2", {17'd0, update_stb}, '0);
        chk("R7 left old at edge 2", left_out, 18'h3C3C3);
        cyc(1);
        chk("R7 strobe high at edge 3", {17'd0, update_stb}, 18'd1);
        chk("R7 left new at edge 3", left_out, 18'h2F00F);
        chk("R7 right new at edge 3", right_out, 18'h11111);
        cyc(1);
        chk("R6 strobe drops", {17'd0, update_stb}, '0);
        cyc(4);

        // Reset mid-frame, then realign (R1, R8)
        send_word(18'h12121, 0, 1'b0);
        rst_n = 1'b0; cyc(2);
        chk("R1 mid-frame left clear", left_out, '0);
        chk("R1 mid-frame right clear", right_out, '0);
        rst_n = 1'b1; wclk = 1'b1; cyc(6);
        s0 = stb_seen;
        wclk = 1'b0; cyc(8);
        chk("R8 realign no strobe", W'(stb_seen - s0), '0);
        frame(18'h00003, 18'h30000, 0);
        chk("R4 after realign right", right_out, 18'h00003);
        chk("R4 after realign left", left_out, 18'h30000);

        done = 1'b1;
        summary();
    end
endmodule